// File: doc/BRIEF.md
# Lock-Loss Edge Interrupt Unit

This block turns three asynchronous health signals from a clock generator into sticky, software-visible event flags and a single interrupt line. Two of the signals are lock indications from a lock detector; the third reports that the reference clock has gone missing. Every input first passes through a synchronizer. After that, each lock indication goes through its own edge detector, and software picks per input whether a rising edge, a falling edge or either edge counts as an event, or switches the source off.

Software programs a 16-bit control word and reads a 16-bit status word. The status word holds the three sticky flags and the live, synchronized level of both lock indications. A flag is cleared by writing a one to its position. A separate control bit turns the lock detector on. While it is off, both lock levels read as zero and the edge detectors also see zero. The interrupt output is the OR of every pending flag whose source is currently enabled.

Top module: `lock_event_irq`

## Requirements
- R1: After reset the control word, the status word and `irq_o` are all zero.
- R2: A control write stores bits 15:11 and bit 7 of the written word. Every other control bit always reads 0.
- R3: Control bits 15:14 choose the event for lock input 1, which sets status bit 15. Control bits 13:12 choose the event for lock input 0, which sets status bit 14. The codes are: 01 for a rising edge, 10 for a falling edge, 11 for either edge, and 00 for no event at all.
- R4: The input path is two flops deep. A lock level that changes between two clock edges shows in status bits 6 (lock 1) and 5 (lock 0) after the second following edge. The matching event flag is set one edge later.
- R5: Status bit 13 sets on every cycle in which the synchronized reference-loss input is high, whatever the value of control bit 11.
- R6: While control bit 7 is 0, status bits 6 and 5 read 0, and the edge detectors see a 0 level. As a result, clearing bit 7 while a lock input is high counts as a falling edge.
- R7: A status write clears each flag at a bit position written as 1 and leaves any flag written as 0 unchanged.
- R8: When a flag's event and a clear of that flag fall on the same clock edge, the flag stays set.
- R9: `irq_o` is high exactly when at least one of these holds: status bit 15 is set and control bits 15:14 are non-zero; status bit 14 is set and control bits 13:12 are non-zero; status bit 13 is set and control bit 11 is 1. A pending flag stays pending when its source is switched off.
- R10: Status bits other than 15, 14, 13, 6 and 5 always read 0, and a status write never changes the level bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lock1_i | input | 1 | Asynchronous lock indication 1 |
| lock0_i | input | 1 | Asynchronous lock indication 0 |
| ref_lost_i | input | 1 | Asynchronous reference-clock-missing indication |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 16 | Control word write data |
| sts_we | input | 1 | Status write strobe (write one to clear) |
| sts_wdata | input | 16 | Status clear mask |
| ctl_rdata | output | 16 | Current control word |
| sts_rdata | output | 16 | Flags and live lock levels |
| irq_o | output | 1 | Interrupt request |

## Verification
The assertions check these properties on every cycle:
- A flag drops only after a write-one to that flag, and a flag that is not being cleared holds.
- Reserved bits read zero, and the level bits are zero while the detector is off.
- A source whose code is 00 never raises its flag.
- The interrupt stays low with every source off and never fires without a flag.

Some behaviour can only be shown by the bench's scenarios:
- The exact latency through the synchronizer.
- Which edge each select code accepts.
- The falling edge created by turning the detector off.
- A flag surviving a clear on the same edge as a new event, both for a lock edge and for a reference loss that is still present.

// File: rtl/lockirq_pkg.sv
package lockirq_pkg;

    localparam int REG_W        = 16;
    localparam int NUM_LOCK     = 2;
    localparam int NUM_SRC      = NUM_LOCK + 1;

    // control word layout
    localparam int CTL_SEL0_LSB = 12;   // lock i select at CTL_SEL0_LSB + 2*i
    localparam int CTL_LOST_EN  = 11;
    localparam int CTL_DET_EN   = 7;

    // status word layout
    localparam int STS_EVT0     = 14;   // lock i flag at STS_EVT0 + i
    localparam int STS_LOST     = 13;
    localparam int STS_LVL0     = 5;    // lock i level at STS_LVL0 + i

    typedef enum logic [1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_ANY  = 2'b11
    } edge_sel_e;

    typedef struct packed {
        edge_sel_e [NUM_LOCK-1:0] sel;
        logic                     lost_en;
        logic                     det_en;
    } ctl_t;

    function automatic logic edge_hit(edge_sel_e s, logic prev, logic cur);
        logic rise;
        logic fall;
        rise = cur & ~prev;
        fall = prev & ~cur;
        case (s)
            EDGE_RISE: edge_hit = rise;
            EDGE_FALL: edge_hit = fall;
            EDGE_ANY:  edge_hit = rise | fall;
            default:   edge_hit = 1'b0;
        endcase
    endfunction

    function automatic int flag_pos(int i);
        flag_pos = (i < NUM_LOCK) ? (STS_EVT0 + i) : STS_LOST;
    endfunction

    function automatic ctl_t unpack_ctl(logic [REG_W-1:0] w);
        ctl_t c;
        for (int i = 0; i < NUM_LOCK; i++)
            c.sel[i] = edge_sel_e'(w[CTL_SEL0_LSB + 2*i +: 2]);
        c.lost_en = w[CTL_LOST_EN];
        c.det_en  = w[CTL_DET_EN];
        unpack_ctl = c;
    endfunction

    function automatic logic [REG_W-1:0] pack_ctl(ctl_t c);
        logic [REG_W-1:0] w;
        w = '0;
        for (int i = 0; i < NUM_LOCK; i++)
            w[CTL_SEL0_LSB + 2*i +: 2] = c.sel[i];
        w[CTL_LOST_EN] = c.lost_en;
        w[CTL_DET_EN]  = c.det_en;
        pack_ctl = w;
    endfunction

endpackage

// File: rtl/lockirq_sync.sv
module lockirq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [STAGES-1:0][WIDTH-1:0] chain;

    always_ff @(posedge clk) begin
        if (rst) begin
            chain <= '0;
        end else begin
            chain[0] <= d;
            for (int s = 1; s < STAGES; s++)
                chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/lockirq_edge.sv
module lockirq_edge
    import lockirq_pkg::*;
#(
    parameter int NUM = NUM_LOCK
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM-1:0]      lvl_i,
    input  logic                det_en,
    input  edge_sel_e [NUM-1:0] sel_i,
    output logic [NUM-1:0]      gated_o,
    output logic [NUM-1:0]      hit_o
);
    logic [NUM-1:0] prev_q;

    assign gated_o = det_en ? lvl_i : '0;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= gated_o;
    end

    for (genvar i = 0; i < NUM; i++) begin : g_det
        assign hit_o[i] = edge_hit(sel_i[i], prev_q[i], gated_o[i]);
    end
endmodule

// File: rtl/lockirq_flags.sv
module lockirq_flags #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] q
);
    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= (q & ~clr_i) | set_i;
    end
endmodule

// File: rtl/lock_event_irq.sv
module lock_event_irq
    import lockirq_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             lock1_i,
    input  logic             lock0_i,
    input  logic             ref_lost_i,
    input  logic             ctl_we,
    input  logic [REG_W-1:0] ctl_wdata,
    input  logic             sts_we,
    input  logic [REG_W-1:0] sts_wdata,
    output logic [REG_W-1:0] ctl_rdata,
    output logic [REG_W-1:0] sts_rdata,
    output logic             irq_o
);
    ctl_t                ctl_q;
    logic [NUM_SRC-1:0]  raw;
    logic [NUM_SRC-1:0]  synced;
    logic [NUM_LOCK-1:0] gated;
    logic [NUM_LOCK-1:0] hit;
    logic [NUM_SRC-1:0]  set_v;
    logic [NUM_SRC-1:0]  clr_v;
    logic [NUM_SRC-1:0]  flag_q;
    logic [NUM_SRC-1:0]  src_en;

    always_ff @(posedge clk) begin
        if (rst)         ctl_q <= '0;
        else if (ctl_we) ctl_q <= unpack_ctl(ctl_wdata);
    end
    assign ctl_rdata = pack_ctl(ctl_q);

    assign raw = {ref_lost_i, lock1_i, lock0_i};

    lockirq_sync #(.WIDTH(NUM_SRC), .STAGES(SYNC_STAGES)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (raw),
        .q   (synced)
    );

    lockirq_edge #(.NUM(NUM_LOCK)) u_edge (
        .clk     (clk),
        .rst     (rst),
        .lvl_i   (synced[NUM_LOCK-1:0]),
        .det_en  (ctl_q.det_en),
        .sel_i   (ctl_q.sel),
        .gated_o (gated),
        .hit_o   (hit)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
        if (i < NUM_LOCK) begin : g_lock
            assign set_v[i]  = hit[i];
            assign src_en[i] = (ctl_q.sel[i] != EDGE_OFF);
        end else begin : g_lost
            assign set_v[i]  = synced[i];
            assign src_en[i] = ctl_q.lost_en;
        end
        assign clr_v[i] = sts_we & sts_wdata[flag_pos(i)];
    end

    lockirq_flags #(.W(NUM_SRC)) u_flags (
        .clk   (clk),
        .rst   (rst),
        .set_i (set_v),
        .clr_i (clr_v),
        .q     (flag_q)
    );

    always_comb begin
        sts_rdata = '0;
        for (int i = 0; i < NUM_SRC; i++)
            sts_rdata[flag_pos(i)] = flag_q[i];
        for (int i = 0; i < NUM_LOCK; i++)
            sts_rdata[STS_LVL0 + i] = gated[i];
    end

    assign irq_o = |(flag_q & src_en);
endmodule

// File: rtl/lockirq_chk.sv
module lockirq_chk (
    input logic        clk,
    input logic        rst,
    input logic        sts_we,
    input logic [15:0] sts_wdata,
    input logic [15:0] ctl_rdata,
    input logic [15:0] sts_rdata,
    input logic        irq_o
);
    p_ctl_unused_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl_rdata & 16'h077F) == 16'h0);

    p_off_no_flag_r3: assert property (@(posedge clk) disable iff (rst)
        (!sts_rdata[15] && ctl_rdata[15:14] == 2'b00) |=> !sts_rdata[15]);

    p_gate_levels_r6: assert property (@(posedge clk) disable iff (rst)
        !ctl_rdata[7] |-> sts_rdata[6:5] == 2'b00);

    p_sticky_l1_r7: assert property (@(posedge clk) disable iff (rst)
        (sts_rdata[15] && !(sts_we && sts_wdata[15])) |=> sts_rdata[15]);

    p_sticky_lost_r7: assert property (@(posedge clk) disable iff (rst)
        (sts_rdata[13] && !(sts_we && sts_wdata[13])) |=> sts_rdata[13]);

    p_clear_needs_write_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(sts_rdata[14]) |-> $past(sts_we && sts_wdata[14]));

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (rst)
        ctl_rdata[15:11] == 5'b0 |-> !irq_o);

    p_irq_has_flag_r9: assert property (@(posedge clk) disable iff (rst)
        irq_o |-> sts_rdata[15:13] != 3'b000);

    p_sts_unused_r10: assert property (@(posedge clk) disable iff (rst)
        (sts_rdata & 16'h1F9F) == 16'h0);
endmodule

bind lock_event_irq lockirq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .sts_we    (sts_we),
    .sts_wdata (sts_wdata),
    .ctl_rdata (ctl_rdata),
    .sts_rdata (sts_rdata),
    .irq_o     (irq_o)
);

// File: tb/lock_event_irq_test.sv
module lock_event_irq_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        lock1 = 1'b0, lock0 = 1'b0, lost = 1'b0;
    logic        ctl_we = 1'b0, sts_we = 1'b0;
    logic [15:0] ctl_wdata = '0, sts_wdata = '0;
    logic [15:0] ctl_rdata, sts_rdata;
    logic        irq;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    typedef struct {
        string       tag;
        logic [15:0] ctl;
        logic [15:0] sts;
        logic        irq;
    } exp_t;
    exp_t sb[$];

    always #2 clk = ~clk;

    lock_event_irq uut (
        .clk        (clk),
        .rst        (rst),
        .lock1_i    (lock1),
        .lock0_i    (lock0),
        .ref_lost_i (lost),
        .ctl_we     (ctl_we),
        .ctl_wdata  (ctl_wdata),
        .sts_we     (sts_we),
        .sts_wdata  (sts_wdata),
        .ctl_rdata  (ctl_rdata),
        .sts_rdata  (sts_rdata),
        .irq_o      (irq)
    );

    // monitor: pops expected items and compares against live outputs
    initial begin
        forever begin
            exp_t e;
            wait (sb.size() != 0);
            e = sb.pop_front();
            checks++;
            if (ctl_rdata !== e.ctl || sts_rdata !== e.sts || irq !== e.irq) begin
                fails++;
                $display("FAIL %s: ctl=%h sts=%h irq=%b expected ctl=%h sts=%h irq=%b",
                         e.tag, ctl_rdata, sts_rdata, irq, e.ctl, e.sts, e.irq);
            end
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic expect_state(string tag, logic [15:0] c, logic [15:0] s, logic i);
        exp_t e;
        e.tag = tag; e.ctl = c; e.sts = s; e.irq = i;
        sb.push_back(e);
        #0;
    endtask

    task automatic wr_ctl(logic [15:0] v);
        ctl_we = 1'b1; ctl_wdata = v;
        tick(1);
        ctl_we = 1'b0; ctl_wdata = '0;
    endtask

    task automatic wr_sts(logic [15:0] v);
        sts_we = 1'b1; sts_wdata = v;
        tick(1);
        sts_we = 1'b0; sts_wdata = '0;
    endtask

    task automatic finish_run();
        wait (sb.size() == 0);
        #1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; fails++;
            $display("FAIL watchdog: run did not complete, expected completion");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        expect_state("R1 reset state", 16'h0000, 16'h0000, 1'b0);

        wr_ctl(16'hFFFF);
        expect_state("R2 control keeps only defined bits", 16'hF880, 16'h0000, 1'b0);
        wr_ctl(16'h6080);   // lock1 rising, lock0 falling, detector on
        expect_state("R2 control rewrite", 16'h6080, 16'h0000, 1'b0);

        lock1 = 1'b1;
        tick(2);
        expect_state("R4 level after two edges, no flag yet", 16'h6080, 16'h0040, 1'b0);
        tick(1);
        expect_state("R4 R3 rising edge flags lock1", 16'h6080, 16'h8040, 1'b1);

        lock0 = 1'b1;
        tick(3);
        expect_state("R3 rise ignored by falling select", 16'h6080, 16'h8060, 1'b1);

        wr_sts(16'h8000);
        expect_state("R7 write one clears lock1 flag", 16'h6080, 16'h0060, 1'b0);

        lock0 = 1'b0;
        tick(3);
        expect_state("R3 falling edge flags lock0", 16'h6080, 16'h4040, 1'b1);
        wr_sts(16'h0000);
        expect_state("R7 write zero keeps flag", 16'h6080, 16'h4040, 1'b1);
        wr_sts(16'hBFFF);
        expect_state("R10 other ones leave flag and level", 16'h6080, 16'h4040, 1'b1);
        wr_sts(16'h4000);
        expect_state("R7 clear lock0 flag", 16'h6080, 16'h0040, 1'b0);

        lock1 = 1'b0;
        tick(3);
        expect_state("R3 fall ignored by rising select", 16'h6080, 16'h0000, 1'b0);

        wr_ctl(16'hF080);   // both any edge
        lock1 = 1'b1;
        tick(3);
        expect_state("R3 any-edge select on rise", 16'hF080, 16'h8040, 1'b1);
        wr_sts(16'h8000);
        lock1 = 1'b0;
        tick(3);
        expect_state("R3 any-edge select on fall", 16'hF080, 16'h8000, 1'b1);
        wr_sts(16'h8000);
        expect_state("R7 clear after any edge", 16'hF080, 16'h0000, 1'b0);

        lock0 = 1'b1;
        tick(3);
        expect_state("R3 lock0 any-edge rise", 16'hF080, 16'h4020, 1'b1);
        wr_ctl(16'hC080);   // lock0 source off
        expect_state("R9 disabled source masks irq, flag kept", 16'hC080, 16'h4020, 1'b0);
        wr_sts(16'h4000);
        lock0 = 1'b0;
        tick(3);
        expect_state("R3 code 00 raises no flag", 16'hC080, 16'h0000, 1'b0);

        lock1 = 1'b1;
        tick(3);
        expect_state("R3 lock1 rise with any", 16'hC080, 16'h8040, 1'b1);
        wr_sts(16'h8000);
        expect_state("R7 cleared before gating", 16'hC080, 16'h0040, 1'b0);
        wr_ctl(16'hC000);   // detector off
        expect_state("R6 levels forced low", 16'hC000, 16'h0000, 1'b0);
        tick(1);
        expect_state("R6 disabling detector is a falling edge", 16'hC000, 16'h8000, 1'b1);
        wr_sts(16'h8000);

        lost = 1'b1;
        tick(3);
        expect_state("R5 loss flag sets without enable", 16'hC000, 16'h2000, 1'b0);
        wr_sts(16'h2000);
        expect_state("R8 loss still present beats clear", 16'hC000, 16'h2000, 1'b0);
        wr_ctl(16'hC800);
        expect_state("R9 loss enable raises irq", 16'hC800, 16'h2000, 1'b1);
        lost = 1'b0;
        tick(3);
        wr_sts(16'h2000);
        expect_state("R7 loss flag clears once input gone", 16'hC800, 16'h0000, 1'b0);

        wr_ctl(16'hC080);   // detector on again while lock1 high
        expect_state("R6 level returns", 16'hC080, 16'h0040, 1'b0);
        tick(1);
        expect_state("R6 enabling detector is a rising edge", 16'hC080, 16'h8040, 1'b1);
        lock1 = 1'b0;
        tick(2);
        wr_sts(16'h8000);   // clear lands on the edge of the new event
        expect_state("R8 event wins over same-edge clear", 16'hC080, 16'h8000, 1'b1);
        wr_sts(16'h8000);
        expect_state("R7 final clear", 16'hC080, 16'h0000, 1'b0);

        rst = 1'b1;
        tick(1);
        rst = 1'b0;
        expect_state("R1 reset after activity", 16'h0000, 16'h0000, 1'b0);

        done = 1;
        finish_run();
    end
endmodule